// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory rank from power-on to a state where normal traffic and periodic refresh can begin. After a start pulse it holds the clock-enable pin low for the power-stabilization interval. It then raises clock enable with a NOP and issues a fixed series of precharge-all, extended and base mode-register writes and auto-refresh commands on the command/bank/address pins. Between commands it inserts a programmable minimum spacing counted in clock cycles.

The base mode-register word is built from a CAS latency, a burst-length code and a write-recovery code. These are sampled, together with a two-chip flag, in the cycle the start pulse is accepted. When the flag is set, the whole series from the NOP onward is replayed with the second chip select. A one-cycle done pulse then tells the surrounding controller to enable its refresh timer. After that the pins rest at NOP with clock enable high.

Top module: `ddr2_init_seq`

## Requirements
- R1: From reset until a start pulse is accepted, `cke_o` is low, both `cs_n_o` bits are high, `ras_n_o`/`cas_n_o`/`we_n_o` are high, `ba_o` and `addr_o` are zero and `done_o` is low.
- R2: A start pulse sampled high while idle begins the run. `cke_o` stays low for exactly CLK_MHZ*PWRUP_US cycles after that sampling edge. It then rises together with a NOP (active chip select low, RAS#/CAS#/WE# = 111) and never falls again until reset. A start pulse at any other time has no effect.
- R3: For each chip the commands appear in this order, each for exactly one cycle: NOP, PALL, EMRS2, EMRS3, EMRS1 (DLL on), MRS (DLL reset), PALL, REF, REF, MRS (DLL run), EMRS1 (OCD default), EMRS1 (OCD exit).
- R4: Command encoding on {CS#, RAS#, CAS#, WE#} is NOP 0111, PALL 0010 with addr bit 10 high, REF 0001, and mode write 0000. For a mode write, `ba_o` selects the register: 0 base, 1 extended-1, 2 extended-2, 3 extended-3.
- R5: EMRS2 and EMRS3 carry an all-zero address. Both the DLL-on EMRS1 and the OCD-exit EMRS1 carry 0x400, which sets bit 10 for single-ended strobe and leaves bit 0 at 0 so the DLL stays enabled. The OCD-default EMRS1 carries 0x780, which sets bits 9:7.
- R6: The MRS address is write-recovery code in bits 11:9, DLL reset in bit 8, CAS latency in bits 6:4 and burst code in bits 2:0, with all other bits zero. The first MRS has bit 8 set and the second has it cleared. CL=4, burst code 2 and WR code 2 give 0x542 and then 0x442.
- R7: Between commands the selected chip sees NOP. The next command follows CKE_CYC = ceil(CKE_NS*CLK_MHZ/1000) cycles after the NOP, T_RP cycles after a PALL, T_RFC after a REF, T_MRD after any other mode write, and max(POST_MRS_CYC, T_MRD) after the second MRS. Every gap is at least 1 cycle.
- R8: With the two-chip flag set at start, the same series is replayed with `cs_n_o` = 01 (chip 1) instead of 10 (chip 0). The replayed NOP comes T_MRD cycles after chip 0's last command.
- R9: `done_o` pulses for one cycle T_MRD cycles after the last command of the last chip. From then until reset, `cke_o` is high, `cs_n_o` is 00 with RAS#/CAS#/WE# high, and start is ignored.
- R10: CAS latency, burst code, write-recovery code and the two-chip flag are used as sampled at start; later changes to them have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up series (sampled while idle) |
| two_chips | input | 1 | Also initialize chip 1 |
| cas_lat | input | 3 | CAS latency for the MRS word |
| burst_code | input | 3 | Burst-length code for the MRS word |
| wr_code | input | 3 | Write-recovery code for the MRS word |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 2 | Active-low chip selects, bit i for chip i |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |
| we_n_o | output | 1 | Active-low write enable |
| ba_o | output | BA_W | Bank address / mode register select |
| addr_o | output | ADDR_W | Address / mode register payload |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_MHZ=10, so the power-up hold is 2000 cycles and the post-NOP wait rounds up to 4. This lets several complete runs, including a two-chip replay, fit easily. T_MRD=2, T_RP=3 and T_RFC=7 are all different, so a gap taken from the wrong class lands on the wrong cycle and shows up. POST_MRS_CYC stays at 200 so the long wait after the second MRS is exercised at its real length. The runs cover a single-chip case with its inputs changed mid-run, a two-chip case with different mode fields, and a reset during the power-up hold.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_NOP       = 4'd0,
    ST_PALL_A    = 4'd1,
    ST_EMR2      = 4'd2,
    ST_EMR3      = 4'd3,
    ST_EMR1_ON   = 4'd4,
    ST_MR_RST    = 4'd5,
    ST_PALL_B    = 4'd6,
    ST_REF_A     = 4'd7,
    ST_REF_B     = 4'd8,
    ST_MR_RUN    = 4'd9,
    ST_EMR1_OCD  = 4'd10,
    ST_EMR1_EXIT = 4'd11
  } step_e;

  localparam step_e STEP_LAST = ST_EMR1_EXIT;

  typedef enum logic [2:0] {
    GAP_CKE,
    GAP_RP,
    GAP_MRD,
    GAP_RFC,
    GAP_POST
  } gap_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PWRUP,
    S_RUN,
    S_FIN
  } fsm_e;

  // {RAS#, CAS#, WE#}; CS# is driven separately per chip
  localparam logic [2:0] CTL_NOP  = 3'b111;
  localparam logic [2:0] CTL_PALL = 3'b010;
  localparam logic [2:0] CTL_REF  = 3'b001;
  localparam logic [2:0] CTL_MODE = 3'b000;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= val;
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R7: a loaded wait starts from the requested value
  a_r7_load_value: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(val)));

  // R7: a running wait shrinks by one every cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3,
  parameter int NUM_CS = 2,
  parameter int CHIP_W = 1
) (
  input  step_e              step_i,
  input  logic [CHIP_W-1:0]  chip_i,
  input  logic [2:0]         cl_i,
  input  logic [2:0]         bl_i,
  input  logic [2:0]         wr_i,
  output logic [NUM_CS-1:0]  cs_n_o,
  output logic [2:0]         ctl_o,
  output logic [BA_W-1:0]    ba_o,
  output logic [ADDR_W-1:0]  addr_o,
  output gap_e               gap_o
);

  localparam logic [ADDR_W-1:0] A10_ONLY = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OCD_DEF  = ADDR_W'(12'h780);

  logic [ADDR_W-1:0] mr_base;

  always_comb begin
    mr_base       = '0;
    mr_base[11:9] = wr_i;
    mr_base[6:4]  = cl_i;
    mr_base[2:0]  = bl_i;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = (chip_i != CHIP_W'(g));
  end

  always_comb begin
    ctl_o  = CTL_NOP;
    ba_o   = '0;
    addr_o = '0;
    gap_o  = GAP_MRD;
    unique case (step_i)
      ST_NOP:       gap_o = GAP_CKE;
      ST_PALL_A,
      ST_PALL_B: begin
        ctl_o  = CTL_PALL;
        addr_o = A10_ONLY;
        gap_o  = GAP_RP;
      end
      ST_EMR2: begin
        ctl_o = CTL_MODE;
        ba_o  = BA_W'(2);
      end
      ST_EMR3: begin
        ctl_o = CTL_MODE;
        ba_o  = BA_W'(3);
      end
      ST_EMR1_ON,
      ST_EMR1_EXIT: begin
        ctl_o  = CTL_MODE;
        ba_o   = BA_W'(1);
        addr_o = A10_ONLY;
      end
      ST_EMR1_OCD: begin
        ctl_o  = CTL_MODE;
        ba_o   = BA_W'(1);
        addr_o = OCD_DEF;
      end
      ST_MR_RST: begin
        ctl_o     = CTL_MODE;
        addr_o    = mr_base;
        addr_o[8] = 1'b1;
      end
      ST_MR_RUN: begin
        ctl_o  = CTL_MODE;
        addr_o = mr_base;
        gap_o  = GAP_POST;
      end
      ST_REF_A,
      ST_REF_B: begin
        ctl_o = CTL_REF;
        gap_o = GAP_RFC;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_MHZ      = 200,
  parameter int PWRUP_US     = 200,
  parameter int CKE_NS       = 400,
  parameter int T_MRD        = 2,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 26,
  parameter int POST_MRS_CYC = 200,
  parameter int ADDR_W       = 14,
  parameter int BA_W         = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              two_chips,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        burst_code,
  input  logic [2:0]        wr_code,
  output logic              cke_o,
  output logic [1:0]        cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int NUM_CS    = 2;
  localparam int CHIP_W    = 1;
  localparam int PWRUP_CYC = at_least_one(CLK_MHZ * PWRUP_US);
  localparam int G_CKE     = at_least_one((CKE_NS * CLK_MHZ + 999) / 1000);
  localparam int G_RP      = at_least_one(T_RP);
  localparam int G_MRD     = at_least_one(T_MRD);
  localparam int G_RFC     = at_least_one(T_RFC);
  localparam int G_POST    = at_least_one(imax(POST_MRS_CYC, T_MRD));
  localparam int MAXW      = imax(imax(PWRUP_CYC, G_CKE),
                                  imax(imax(G_RP, G_MRD), imax(G_RFC, G_POST)));
  localparam int TMR_W     = $clog2(MAXW + 1);

  fsm_e              state;
  step_e             step, nxt_step;
  logic [CHIP_W-1:0] chip, nxt_chip;
  logic              two_q;
  logic [2:0]        cl_q, bl_q, wr_q;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val, gap_m1;

  logic [NUM_CS-1:0] rom_cs_n, cur_sel_n;
  logic [2:0]        rom_ctl;
  logic [BA_W-1:0]   rom_ba;
  logic [ADDR_W-1:0] rom_addr;
  gap_e              rom_gap;

  logic at_last, more_chips;

  assign at_last    = (step == STEP_LAST);
  assign more_chips = two_q && (chip == CHIP_W'(0));

  always_comb begin
    if (state == S_PWRUP) begin
      nxt_step = ST_NOP;
      nxt_chip = '0;
    end else if (at_last) begin
      nxt_step = ST_NOP;
      nxt_chip = CHIP_W'(1);
    end else begin
      nxt_step = step_e'(4'(step) + 4'd1);
      nxt_chip = chip;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CS; i++)
      cur_sel_n[i] = (chip != CHIP_W'(i));
  end

  ddr2_init_step_rom #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .NUM_CS (NUM_CS),
    .CHIP_W (CHIP_W)
  ) rom_i (
    .step_i (nxt_step),
    .chip_i (nxt_chip),
    .cl_i   (cl_q),
    .bl_i   (bl_q),
    .wr_i   (wr_q),
    .cs_n_o (rom_cs_n),
    .ctl_o  (rom_ctl),
    .ba_o   (rom_ba),
    .addr_o (rom_addr),
    .gap_o  (rom_gap)
  );

  always_comb begin
    unique case (rom_gap)
      GAP_CKE:  gap_m1 = TMR_W'(G_CKE - 1);
      GAP_RP:   gap_m1 = TMR_W'(G_RP - 1);
      GAP_RFC:  gap_m1 = TMR_W'(G_RFC - 1);
      GAP_POST: gap_m1 = TMR_W'(G_POST - 1);
      default:  gap_m1 = TMR_W'(G_MRD - 1);
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = gap_m1;
    unique case (state)
      S_IDLE: begin
        tmr_load = start;
        tmr_val  = TMR_W'(PWRUP_CYC - 1);
      end
      S_PWRUP: tmr_load = tmr_zero;
      S_RUN:   tmr_load = tmr_zero && (!at_last || more_chips);
      default: ;
    endcase
  end

  ddr2_init_timer #(.W(TMR_W)) tmr_i (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      step    <= ST_NOP;
      chip    <= '0;
      two_q   <= 1'b0;
      cl_q    <= '0;
      bl_q    <= '0;
      wr_q    <= '0;
      cke_o   <= 1'b0;
      cs_n_o  <= '1;
      {ras_n_o, cas_n_o, we_n_o} <= CTL_NOP;
      ba_o    <= '0;
      addr_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            two_q <= two_chips;
            cl_q  <= cas_lat;
            bl_q  <= burst_code;
            wr_q  <= wr_code;
            state <= S_PWRUP;
          end
        end
        S_PWRUP: begin
          if (tmr_zero) begin
            cke_o  <= 1'b1;
            cs_n_o <= rom_cs_n;
            {ras_n_o, cas_n_o, we_n_o} <= rom_ctl;
            ba_o   <= rom_ba;
            addr_o <= rom_addr;
            step   <= nxt_step;
            chip   <= nxt_chip;
            state  <= S_RUN;
          end
        end
        S_RUN: begin
          if (tmr_zero && (!at_last || more_chips)) begin
            cs_n_o <= rom_cs_n;
            {ras_n_o, cas_n_o, we_n_o} <= rom_ctl;
            ba_o   <= rom_ba;
            addr_o <= rom_addr;
            step   <= nxt_step;
            chip   <= nxt_chip;
          end else if (tmr_zero) begin
            cs_n_o <= '0;
            {ras_n_o, cas_n_o, we_n_o} <= CTL_NOP;
            ba_o   <= '0;
            addr_o <= '0;
            done_o <= 1'b1;
            state  <= S_FIN;
          end else begin
            cs_n_o <= cur_sel_n;
            {ras_n_o, cas_n_o, we_n_o} <= CTL_NOP;
            ba_o   <= '0;
            addr_o <= '0;
          end
        end
        default: done_o <= 1'b0;
      endcase
    end
  end

  // R1: while clock enable is low the bus is deselected and quiet
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> (cs_n_o == '1 && ras_n_o && cas_n_o && we_n_o && !done_o));

  // R2: clock enable rises together with a NOP on exactly one chip
  a_r2_cke_rise_nop: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> (ras_n_o && cas_n_o && we_n_o && $countones(~cs_n_o) == 1));

  // R2: once high, clock enable stays high
  a_r2_cke_hold: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o);

  // R4: precharge-all carries address bit 10
  a_r4_pall_a10: assert property (@(posedge clk) disable iff (rst)
    (!ras_n_o && cas_n_o && !we_n_o && cs_n_o != '1) |-> addr_o[10]);

  // R5: extended registers 2 and 3 are written with zero
  a_r5_emr23_zero: assert property (@(posedge clk) disable iff (rst)
    ({ras_n_o, cas_n_o, we_n_o} == CTL_MODE && cs_n_o != '1 &&
     (ba_o == BA_W'(2) || ba_o == BA_W'(3))) |-> (addr_o == '0));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: done comes with the resting NOP bus
  a_r9_done_bus: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cke_o && cs_n_o == '0 && ras_n_o && cas_n_o && we_n_o));

endmodule

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;

  localparam int CLK_PERIOD   = 10;
  localparam int CLK_MHZ      = 10;
  localparam int PWRUP_US     = 200;
  localparam int CKE_NS       = 400;
  localparam int T_MRD        = 2;
  localparam int T_RP         = 3;
  localparam int T_RFC        = 7;
  localparam int POST_MRS_CYC = 200;
  localparam int ADDR_W       = 14;
  localparam int BA_W         = 3;
  localparam int WW           = 2 + 3 + BA_W + ADDR_W;
  localparam int M_PWR        = CLK_MHZ * PWRUP_US;
  localparam int M_CKE        = (CKE_NS * CLK_MHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst, start, two_chips;
  logic [2:0] cas_lat, burst_code, wr_code;
  logic cke_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [1:0] cs_n_o;
  logic [BA_W-1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr2_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .CKE_NS(CKE_NS),
    .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .POST_MRS_CYC(POST_MRS_CYC),
    .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .two_chips(two_chips),
    .cas_lat(cas_lat), .burst_code(burst_code), .wr_code(wr_code),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .done_o(done_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  function automatic int gap_of(input int s);
    int g;
    case (s)
      0:       g = M_CKE;
      1, 6:    g = T_RP;
      7, 8:    g = T_RFC;
      9:       g = (POST_MRS_CYC > T_MRD) ? POST_MRS_CYC : T_MRD;
      default: g = T_MRD;
    endcase
    return (g < 1) ? 1 : g;
  endfunction

  function automatic int mrw(input int dll, input int cl, input int bl, input int wr);
    return (wr << 9) | (dll << 8) | (cl << 4) | bl;
  endfunction

  function automatic logic [WW-1:0] mk(input logic [1:0] cs, input logic [2:0] ctl,
                                       input int ba, input int addr);
    return {cs, ctl, BA_W'(ba), ADDR_W'(addr)};
  endfunction

  // behavioural reference
  int ev_at[$];
  logic [WW-1:0] ev_word[$];
  string ev_tag[$];
  logic [WW-1:0] exp_cmds[$];
  logic [WW-1:0] act_log[$];
  int m_state = 0;
  int m_t = 0;
  int done_at = 0;
  int m_cl, m_bl, m_wr;
  bit model_ok = 0;
  logic e_cke, e_done;
  logic [WW-1:0] e_word;
  string e_tag;

  task automatic build_schedule(input bit two, input int cl, input int bl, input int wr);
    int t;
    logic [1:0] cs;
    logic [WW-1:0] w;
    string tg;
    ev_at.delete(); ev_word.delete(); ev_tag.delete(); exp_cmds.delete();
    t = M_PWR;
    for (int c = 0; c < (two ? 2 : 1); c++) begin
      cs = (c == 0) ? 2'b10 : 2'b01;
      for (int s = 0; s < 12; s++) begin
        case (s)
          0:        begin w = mk(cs, 3'b111, 0, 0);                tg = "R2"; end
          1, 6:     begin w = mk(cs, 3'b010, 0, 'h400);            tg = "R4"; end
          2:        begin w = mk(cs, 3'b000, 2, 0);                tg = "R5"; end
          3:        begin w = mk(cs, 3'b000, 3, 0);                tg = "R5"; end
          4, 11:    begin w = mk(cs, 3'b000, 1, 'h400);            tg = "R5"; end
          5:        begin w = mk(cs, 3'b000, 0, mrw(1, cl, bl, wr)); tg = "R6"; end
          7, 8:     begin w = mk(cs, 3'b001, 0, 0);                tg = "R4"; end
          9:        begin w = mk(cs, 3'b000, 0, mrw(0, cl, bl, wr)); tg = "R6"; end
          default:  begin w = mk(cs, 3'b000, 1, 'h780);            tg = "R5"; end
        endcase
        if (c == 1) tg = "R8";
        ev_at.push_back(t);
        ev_word.push_back(w);
        ev_tag.push_back(tg);
        if (s != 0) exp_cmds.push_back(w);
        t += gap_of(s);
      end
    end
    done_at = t;
  endtask

  always @(posedge clk) begin
    int idx;
    model_ok = 1;
    if (rst) begin
      m_state = 0;
    end else if (m_state == 0) begin
      if (start) begin
        m_cl = cas_lat; m_bl = burst_code; m_wr = wr_code;
        build_schedule(two_chips, m_cl, m_bl, m_wr);
        m_t = 0;
        m_state = 1;
      end
    end else begin
      m_t++;
    end
    if (m_state == 0 || m_t < M_PWR) begin
      e_cke = 0; e_done = 0;
      e_word = mk(2'b11, 3'b111, 0, 0);
      e_tag = (m_state == 0) ? "R1" : "R2";
    end else if (m_t < done_at) begin
      idx = 0;
      for (int i = 0; i < ev_at.size(); i++)
        if (ev_at[i] <= m_t) idx = i;
      e_cke = 1; e_done = 0;
      if (ev_at[idx] == m_t) begin
        e_word = ev_word[idx];
        e_tag = ev_tag[idx];
      end else begin
        e_word = mk(ev_word[idx][WW-1 -: 2], 3'b111, 0, 0);
        e_tag = "R7";
      end
    end else begin
      e_cke = 1;
      e_done = (m_t == done_at);
      e_word = mk(2'b00, 3'b111, 0, 0);
      e_tag = "R9";
    end
  end

  always @(negedge clk) begin
    logic [WW-1:0] a_word;
    if (model_ok && !finished) begin
      a_word = {cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o};
      chk(cke_o === e_cke, e_tag, "cke", 64'(cke_o), 64'(e_cke));
      chk(a_word === e_word, e_tag, "bus", 64'(a_word), 64'(e_word));
      chk(done_o === e_done, "R9", "done", 64'(done_o), 64'(e_done));
      if (!rst && cke_o && cs_n_o != 2'b11 && {ras_n_o, cas_n_o, we_n_o} != 3'b111)
        act_log.push_back(a_word);
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!(m_state == 1 && m_t > done_at + 5)) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_log();
    chk(act_log.size() == exp_cmds.size(), "R3", "command count",
        64'(act_log.size()), 64'(exp_cmds.size()));
    if (act_log.size() == exp_cmds.size()) begin
      for (int k = 0; k < exp_cmds.size(); k++)
        chk(act_log[k] === exp_cmds[k], "R3", "command order", 64'(act_log[k]), 64'(exp_cmds[k]));
      // R10: the DLL-reset MRS reflects the values held at start
      chk(act_log[4][ADDR_W-1:0] === ADDR_W'(mrw(1, m_cl, m_bl, m_wr)), "R10", "latched MRS",
          64'(act_log[4][ADDR_W-1:0]), 64'(mrw(1, m_cl, m_bl, m_wr)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL R9 watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; start = 0; two_chips = 0;
    cas_lat = 3'd4; burst_code = 3'd2; wr_code = 3'd2;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (6) @(negedge clk);              // R1 idle
    // run 1: single chip, 0x542 / 0x442, inputs disturbed mid-run (R10)
    act_log.delete();
    pulse_start();
    repeat (10) @(negedge clk);
    cas_lat = 3'd6; burst_code = 3'd3; wr_code = 3'd5; two_chips = 1;
    pulse_start();                          // R2 ignored while busy
    wait_done();
    pulse_start();                          // R9 ignored after done
    repeat (8) @(negedge clk);
    check_log();
    chk(exp_cmds.size() == 11, "R8", "single chip series length",
        64'(exp_cmds.size()), 64'd11);
    // run 2: two chips, other mode fields
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    act_log.delete();
    two_chips = 1; cas_lat = 3'd5; burst_code = 3'd3; wr_code = 3'd1;
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done();
    check_log();
    // run 3: reset during the power-up hold
    rst = 1;
    @(negedge clk);
    rst = 0;
    two_chips = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (20) @(negedge clk);             // R1 after reset
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule